// File: doc/BRIEF.md
# Multiply Unit with Gated Stuck-At Fault Injection

This block executes one 32-bit multiply instruction per issue cycle and writes the low half of the unsigned product back to a 16-entry register file that sits outside the block. It decodes three register indices from the instruction word. It drives the two source indices to the register file's read ports and receives the operand values back in the same cycle. One clock later it presents a single write of the result.

A fault hook wraps the execution. The faulty path is taken only when four conditions hold at once. The opcode must be marked as susceptible, the processor must be running unprivileged, the fault-enable word must be nonzero, and a user-supplied condition bit must be high. On that path the written value is the product with its least significant bit stuck at one. A replace flag goes high to tell the core that the faulty result stands in for the normal instruction, which must not also execute. The unit also reports a cycle cost for the executed variant, and the faulty variant may have a different cost from the correct one.

Top module: `fault_mul_unit`

## Requirements
- R1: While reset is asserted and after it is released with no issue, `wr_en_o` and `replace_o` are 0.
- R2: The source read indices are combinational from the instruction word: `src_a_addr_o` = bits 11:8 and `src_b_addr_o` = bits 3:0. The write index `wr_addr_o` equals bits 19:16 of the issued word.
- R3: Exactly one cycle after an issue, `wr_en_o` is 1 and `wr_data_o` holds the low 32 bits of the unsigned product of the two source values when no fault is taken.
- R4: When the fault is taken, `wr_data_o` equals that product with bit 0 forced to 1. All other bits are unchanged.
- R5: The fault is taken only if the susceptible mark is 1, the privileged flag is 0, the fault-enable word has any bit set, and the user condition is 1. If any one of these fails, the result is the plain product.
- R6: `replace_o` is 1 in the write-back cycle exactly when the fault was taken. It is 0 whenever the privileged flag was set or the enable word was zero.
- R7: In the write-back cycle, `cost_o` equals FAULT_COST (default 1) when the fault was taken and NORMAL_COST (default 3) otherwise.
- R8: A cycle with no issue produces `wr_en_o` = 0 and `replace_o` = 0 in the following cycle, and no register-file value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | A multiply instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| priv_i | input | 1 | Processor is in privileged mode |
| fault_en_i | input | 32 | Fault-enable word; nonzero enables faults |
| susceptible_i | input | 1 | Opcode is marked fault-susceptible |
| user_cond_i | input | 1 | User-defined fault condition hook |
| src_a_addr_o | output | 4 | Register file read index, first source |
| src_b_addr_o | output | 4 | Register file read index, second source |
| src_a_data_i | input | 32 | First source value |
| src_b_data_i | input | 32 | Second source value |
| wr_en_o | output | 1 | Register file write strobe |
| wr_addr_o | output | 4 | Destination register index |
| wr_data_o | output | 32 | Value written back |
| replace_o | output | 1 | Faulty path replaced the normal instruction |
| cost_o | output | 4 | Cycle cost of the executed variant |

## Verification
Operands are chosen so that the low product bit can show the fault. An even product shows the stuck bit directly. An odd product must stay the same under a fault, which separates an OR-based fault from an XOR or inversion. A full-width operand pair checks that the product is truncated and not saturated. Each of the four gate conditions is dropped in turn while the other three stay true, so a missing term in the conjunction is caught. An enable word with only its top bit set checks that the whole word counts, not only its low bit. Back-to-back issues and idle gaps check that the single-cycle write-back neither repeats nor leaks a replace flag.

// File: rtl/fmu_pkg.sv
package fmu_pkg;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned REG_AW   = 4;
  localparam int unsigned DST_LSB  = 16;
  localparam int unsigned SRCA_LSB = 8;
  localparam int unsigned SRCB_LSB = 0;

  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
  } mul_fields_t;
endpackage

// File: rtl/fmu_decode.sv
module fmu_decode
  import fmu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output mul_fields_t        fields
);
  always_comb begin
    fields.dst   = instr[DST_LSB  +: REG_AW];
    fields.src_a = instr[SRCA_LSB +: REG_AW];
    fields.src_b = instr[SRCB_LSB +: REG_AW];
  end
endmodule

// File: rtl/fmu_fault_gate.sv
module fmu_fault_gate #(
  parameter int unsigned EN_W = 32
) (
  input  logic            susceptible,
  input  logic            priv,
  input  logic [EN_W-1:0] fault_en,
  input  logic            user_cond,
  output logic            take_fault
);
  logic enabled;

  always_comb begin
    enabled    = |fault_en;
    take_fault = susceptible & ~priv & enabled & user_cond;
  end
endmodule

// File: rtl/fmu_mul_core.sv
module fmu_mul_core #(
  parameter int unsigned W         = 32,
  parameter int unsigned STUCK_BIT = 0,
  parameter bit          STUCK_ONE = 1'b1
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         fault,
  output logic [W-1:0] result
);
  logic [W-1:0] product;

  always_comb product = op_a * op_b;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == STUCK_BIT) begin : g_stuck
      if (STUCK_ONE) begin : g_one
        assign result[i] = product[i] | fault;
      end else begin : g_zero
        assign result[i] = product[i] & ~fault;
      end
    end else begin : g_pass
      assign result[i] = product[i];
    end
  end
endmodule

// File: rtl/fault_mul_unit.sv
module fault_mul_unit
  import fmu_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned EN_W        = 32,
  parameter int unsigned COST_W      = 4,
  parameter int unsigned NORMAL_COST = 3,
  parameter int unsigned FAULT_COST  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                priv_i,
  input  logic [EN_W-1:0]     fault_en_i,
  input  logic                susceptible_i,
  input  logic                user_cond_i,
  output logic [REG_AW-1:0]   src_a_addr_o,
  output logic [REG_AW-1:0]   src_b_addr_o,
  input  logic [DATA_W-1:0]   src_a_data_i,
  input  logic [DATA_W-1:0]   src_b_data_i,
  output logic                wr_en_o,
  output logic [REG_AW-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                replace_o,
  output logic [COST_W-1:0]   cost_o
);
  localparam logic [COST_W-1:0] COST_OK  = COST_W'(NORMAL_COST);
  localparam logic [COST_W-1:0] COST_BAD = COST_W'(FAULT_COST);

  mul_fields_t       fields;
  logic              take_fault;
  logic [DATA_W-1:0] result;

  fmu_decode u_dec (
    .instr  (instr_i),
    .fields (fields)
  );

  fmu_fault_gate #(.EN_W(EN_W)) u_gate (
    .susceptible (susceptible_i),
    .priv        (priv_i),
    .fault_en    (fault_en_i),
    .user_cond   (user_cond_i),
    .take_fault  (take_fault)
  );

  fmu_mul_core #(.W(DATA_W), .STUCK_BIT(0), .STUCK_ONE(1'b1)) u_mul (
    .op_a   (src_a_data_i),
    .op_b   (src_b_data_i),
    .fault  (take_fault),
    .result (result)
  );

  assign src_a_addr_o = fields.src_a;
  assign src_b_addr_o = fields.src_b;

  // next-state
  logic              wr_en_d, replace_d, data_ce;
  logic [REG_AW-1:0] wr_addr_d;
  logic [DATA_W-1:0] wr_data_d;
  logic [COST_W-1:0] cost_d;

  always_comb begin
    data_ce   = issue_i;
    wr_en_d   = issue_i;
    replace_d = issue_i & take_fault;
    wr_addr_d = fields.dst;
    wr_data_d = result;
    cost_d    = take_fault ? COST_BAD : COST_OK;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      replace_o <= 1'b0;
    end else begin
      wr_en_o   <= wr_en_d;
      replace_o <= replace_d;
    end
  end

  // data registers with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_o <= '0;
      wr_data_o <= '0;
      cost_o    <= '0;
    end else if (data_ce) begin
      wr_addr_o <= wr_addr_d;
      wr_data_o <= wr_data_d;
      cost_o    <= cost_d;
    end
  end
endmodule

// File: rtl/fault_mul_unit_checker.sv
module fault_mul_unit_checker #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned EN_W        = 32,
  parameter int unsigned COST_W      = 4,
  parameter int unsigned NORMAL_COST = 3,
  parameter int unsigned FAULT_COST  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_i,
  input logic [31:0]       instr_i,
  input logic              priv_i,
  input logic [EN_W-1:0]   fault_en_i,
  input logic              susceptible_i,
  input logic              user_cond_i,
  input logic              wr_en_o,
  input logic [3:0]        wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              replace_o,
  input logic [COST_W-1:0] cost_o
);
  AST_WB_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> wr_en_o); // R3
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!wr_en_o && !replace_o)); // R8
  AST_DEST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (wr_addr_o == $past(instr_i[19:16]))); // R2
  AST_GATE_ALL_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !(susceptible_i && !priv_i && (fault_en_i != '0) && user_cond_i)) |=> !replace_o); // R5
  AST_FAULT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && susceptible_i && !priv_i && (fault_en_i != '0) && user_cond_i) |=> replace_o); // R6
  AST_STUCK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    replace_o |-> wr_data_o[0]); // R4
  AST_COST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (cost_o == (replace_o ? COST_W'(FAULT_COST) : COST_W'(NORMAL_COST)))); // R7
  AST_REPLACE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    replace_o |-> wr_en_o); // R6
endmodule

bind fault_mul_unit fault_mul_unit_checker #(
  .DATA_W(DATA_W), .EN_W(EN_W), .COST_W(COST_W),
  .NORMAL_COST(NORMAL_COST), .FAULT_COST(FAULT_COST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
  .priv_i(priv_i), .fault_en_i(fault_en_i), .susceptible_i(susceptible_i),
  .user_cond_i(user_cond_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o), .replace_o(replace_o), .cost_o(cost_o)
);

// File: tb/sim_fault_mul_unit.sv
`timescale 1ns/1ps
module sim_fault_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [31:0] instr_i;
  logic        priv_i;
  logic [31:0] fault_en_i;
  logic        susceptible_i;
  logic        user_cond_i;
  logic [3:0]  src_a_addr_o, src_b_addr_o;
  logic [31:0] src_a_data_i, src_b_data_i;
  logic        wr_en_o;
  logic [3:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic        replace_o;
  logic [3:0]  cost_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rf [16];

  always #10 clk = ~clk;

  fault_mul_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
    .priv_i(priv_i), .fault_en_i(fault_en_i), .susceptible_i(susceptible_i),
    .user_cond_i(user_cond_i), .src_a_addr_o(src_a_addr_o),
    .src_b_addr_o(src_b_addr_o), .src_a_data_i(src_a_data_i),
    .src_b_data_i(src_b_data_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .replace_o(replace_o), .cost_o(cost_o)
  );

  // bench-side register file read ports
  always_comb begin
    src_a_data_i = rf[src_a_addr_o];
    src_b_data_i = rf[src_b_addr_o];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int d, input int a, input int b);
    logic [31:0] w;
    w = 32'hE000_0090;
    w[19:16] = d[3:0];
    w[11:8]  = a[3:0];
    w[3:0]   = b[3:0];
    return w;
  endfunction

  // issue one multiply and compare the write-back one cycle later
  task automatic run_mul(input int d, input int a, input int b, input logic prv,
                         input logic [31:0] fen, input logic sus, input logic cnd,
                         input string req);
    logic [31:0] exp_data;
    logic        exp_flt;
    exp_flt  = sus && !prv && (fen != 0) && cnd;
    exp_data = 32'(64'(rf[a]) * 64'(rf[b]));
    if (exp_flt) exp_data = exp_data | 32'd1;
    issue_i = 1'b1; instr_i = mk(d, a, b);
    priv_i = prv; fault_en_i = fen; susceptible_i = sus; user_cond_i = cnd;
    #1;
    check({req, " R2 src_a index"}, 32'(src_a_addr_o), 32'(a));
    check({req, " R2 src_b index"}, 32'(src_b_addr_o), 32'(b));
    @(posedge clk);
    @(negedge clk);
    issue_i = 1'b0;
    check({req, " R3 wr_en"}, 32'(wr_en_o), 32'd1);
    check({req, " R2 wr_addr"}, 32'(wr_addr_o), 32'(d));
    check({req, exp_flt ? " R4 data" : " R3 data"}, wr_data_o, exp_data);
    check({req, exp_flt ? " R6 replace" : " R5 replace"}, 32'(replace_o), 32'(exp_flt));
    check({req, " R7 cost"}, 32'(cost_o), exp_flt ? 32'd1 : 32'd3);
    rf[d] = exp_data;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + 32'(i * 7 + 1);
    rf[1] = 32'd6;  rf[2] = 32'd7;  rf[3] = 32'd5;
    rf[4] = 32'hFFFF_FFFF; rf[5] = 32'hFFFF_FFFF;
    rf[6] = 32'd0;  rf[7] = 32'h0001_0000; rf[8] = 32'h0003_0000;
    rst_n = 1'b0; issue_i = 1'b0; instr_i = '0; priv_i = 1'b0;
    fault_en_i = '0; susceptible_i = 1'b0; user_cond_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 wr_en in reset", 32'(wr_en_o), 32'd0);
    check("R1 replace in reset", 32'(replace_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wr_en after release", 32'(wr_en_o), 32'd0);
    check("R1 replace after release", 32'(replace_o), 32'd0);

    run_mul(9, 1, 2, 1'b0, 32'd0, 1'b1, 1'b1, "plain even product");
    run_mul(10, 2, 3, 1'b0, 32'd1, 1'b1, 1'b1, "fault on odd product");
    run_mul(11, 1, 3, 1'b0, 32'd1, 1'b1, 1'b1, "fault on even product");
    run_mul(12, 4, 5, 1'b0, 32'd0, 1'b0, 1'b0, "full width truncation");
    run_mul(13, 7, 8, 1'b0, 32'h8000_0000, 1'b1, 1'b1, "top enable bit");
    run_mul(14, 6, 2, 1'b1, 32'd1, 1'b1, 1'b1, "R6 privileged blocks");
    run_mul(14, 1, 1, 1'b0, 32'd5, 1'b0, 1'b1, "R5 not susceptible");
    run_mul(15, 1, 2, 1'b0, 32'd5, 1'b1, 1'b0, "R5 user cond low");
    run_mul(0, 1, 3, 1'b0, 32'd0, 1'b1, 1'b1, "R6 enable zero");

    // idle gap: no write, no replace
    @(posedge clk); @(negedge clk);
    check("R8 idle wr_en", 32'(wr_en_o), 32'd0);
    check("R8 idle replace", 32'(replace_o), 32'd0);

    // back-to-back, chaining a written register
    run_mul(1, 10, 2, 1'b0, 32'd2, 1'b1, 1'b1, "chain uses faulty value");
    run_mul(2, 1, 1, 1'b0, 32'd0, 1'b1, 1'b1, "chain square");
    @(posedge clk); @(negedge clk);
    check("R8 idle after chain", 32'(wr_en_o), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule